// File: doc/BRIEF.md
# Buffered Program Sequence Controller

This block runs the multi-cycle buffered write sequence of a small simulated nonvolatile byte array. A command front end hands it one latched bus write per cycle, made of an address, a 16-bit data value and a byte/word flag. The sequence has four steps. A setup write opens it. A count write gives N. Exactly N+1 data writes follow, and they land in an internal staging buffer. A confirm write comes last. After the confirm, a program engine runs for a fixed number of busy cycles and then merges the staged bytes into the array. Programming can only clear bits.

Software polls two status bytes. The main status byte carries a ready flag and two sticky error flags. The extended status byte carries a buffer-available flag. Three things are sequence errors: a count that is too large, a data address outside the buffer window, and a wrong code in the confirm slot. Each one abandons the sequence without programming and sets both error flags. While the error flags are set, new sequences are refused until a clear command is written.

Top module: `bufprog_top`

## Requirements
- R1: After reset, the status byte reads 80h, the extended status byte reads 80h, and every array byte reads FFh.
- R2: In idle, a write whose low data byte is E8h starts a sequence, provided no error flag is set. Any other write in idle, except the clear code 50h, has no effect on status or array.
- R3: The write after setup is the count N, compared over all 16 data bits. The maximum is 1Fh in byte mode and 000Fh in word mode, where the mode is the one latched at setup. A larger count returns to idle and sets status bit 5 and bit 4.
- R4: Exactly N+1 data writes follow the count. A write of D0h (low byte) in the next slot starts programming.
- R5: Any other value in the confirm slot abandons the sequence, leaves the array unchanged, and sets status bits 5 and 4.
- R6: The first data write fixes base address B. Each data write must use an address A with (A-B) mod 128 no greater than N, in byte units in byte mode and word units in word mode. Any other address abandons the sequence without programming and sets status bits 5 and 4.
- R7: While status bit 4 or 5 is set, an E8h write is refused. The extended bit 7 reads 0, and the count, data and confirm writes that follow program nothing.
- R8: A write of 50h in idle clears status bits 5 and 4.
- R9: After the confirm, status bit 7 (ready) and extended bit 7 (available) are both 0 for exactly PROG_CYCLES cycles, then both return to 1.
- R10: On completion, every staged byte is ANDed into its cell: cell = old AND data. A later data write to the same offset replaces the earlier one. Offsets that were never written are untouched. In word mode, word address W maps to byte 2W (data bits 7:0) and byte 2W+1 (bits 15:8).
- R11: Writes that arrive while the engine is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One latched bus write this cycle |
| wrAddr | input | ADDR_W | Write address (byte units in byte mode, word units in word mode) |
| wrData | input | 16 | Write data or command code |
| byteMode | input | 1 | 1 = byte mode, 0 = word mode; sampled at setup |
| rdAddr | input | ADDR_W | Array byte address for readback |
| rdData | output | 8 | Array byte at rdAddr |
| statusOut | output | 8 | Bit 7 ready, bit 5 and bit 4 sequence error, others 0 |
| xStatusOut | output | 8 | Bit 7 buffer available, others 0 |

## Verification
The assertions assume that wrEn is never X after reset. They also assume that the busy period begins only through a confirm write and that the error flags are cleared only by the 50h code, which means no other agent touches the status. The stimulus stays within these assumptions. Every write is a single-cycle pulse driven on the falling edge. Random sequences draw counts inside the legal range for their mode, and every data offset falls inside the window. Illegal counts, wrong confirms and out-of-window addresses appear only in directed cases, each followed by a clear.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_DATA, ST_CONFIRM, ST_PROG
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startSeq;
    logic takeCount;
    logic takeData;
    logic commit;
  } dpCtrl_t;
endpackage

// File: rtl/bufprog_dp.sv
module bufprog_dp
  import bufprog_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              countOk,
  output logic              inRange,
  output logic              lastData
);
  localparam int ARR_BYTES    = 1 << ADDR_W;
  localparam int IDX_W        = $clog2(BUF_BYTES);
  localparam int MAX_BYTE_CNT = BUF_BYTES - 1;
  localparam int MAX_WORD_CNT = BUF_BYTES / 2 - 1;

  logic              modeByte;
  logic [IDX_W-1:0]  cntN;
  logic [IDX_W-1:0]  recvCnt;
  logic [ADDR_W-1:0] baseAddr;
  logic              haveBase;
  logic [7:0]        bufMem  [BUF_BYTES];
  logic [BUF_BYTES-1:0] bufMask;
  logic [7:0]        arrMem  [ARR_BYTES];

  logic [ADDR_W-1:0] offRaw;
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] baseByte;

  always_comb begin
    offRaw   = wrAddr - (haveBase ? baseAddr : wrAddr);
    inRange  = offRaw <= ADDR_W'(cntN);
    slot     = modeByte ? IDX_W'(offRaw) : IDX_W'({offRaw, 1'b0});
    baseByte = modeByte ? baseAddr : {baseAddr[ADDR_W-2:0], 1'b0};
    countOk  = modeByte ? (wrData <= 16'(MAX_BYTE_CNT)) : (wrData <= 16'(MAX_WORD_CNT));
    lastData = recvCnt == cntN;
  end

  assign rdData = arrMem[rdAddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeByte <= 1'b1;
      cntN     <= '0;
      recvCnt  <= '0;
      baseAddr <= '0;
      haveBase <= 1'b0;
      bufMask  <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= 8'hFF;
      for (int i = 0; i < ARR_BYTES; i++) arrMem[i] <= 8'hFF;
    end else begin
      if (ctl.startSeq) begin
        modeByte <= byteMode;
        recvCnt  <= '0;
        haveBase <= 1'b0;
        bufMask  <= '0;
      end
      if (ctl.takeCount) cntN <= wrData[IDX_W-1:0];
      if (ctl.takeData) begin
        if (!haveBase) begin
          baseAddr <= wrAddr;
          haveBase <= 1'b1;
        end
        recvCnt       <= recvCnt + 1'b1;
        bufMem[slot]  <= wrData[7:0];
        bufMask[slot] <= 1'b1;
        if (!modeByte) begin
          bufMem[IDX_W'(slot + 1'b1)]  <= wrData[15:8];
          bufMask[IDX_W'(slot + 1'b1)] <= 1'b1;
        end
      end
      if (ctl.commit) begin
        for (int i = 0; i < BUF_BYTES; i++) begin
          if (bufMask[i])
            arrMem[ADDR_W'(baseByte + ADDR_W'(i))] <= arrMem[ADDR_W'(baseByte + ADDR_W'(i))] & bufMem[i];
        end
      end
    end
  end
endmodule

// File: rtl/bufprog_ctrl.sv
module bufprog_ctrl
  import bufprog_pkg::*;
#(
  parameter int PROG_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  input  logic       countOk,
  input  logic       inRange,
  input  logic       lastData,
  output dpCtrl_t    ctl,
  output logic       ready,
  output logic       avail,
  output logic       progErr,
  output logic       eraseErr
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  seqState_t        state, nxtState;
  logic [CNT_W-1:0] busyCnt;
  logic             seqErr, clrErr, loadBusy;
  logic             anyErr;

  assign anyErr = progErr | eraseErr;

  always_comb begin
    ctl      = '0;
    nxtState = state;
    seqErr   = 1'b0;
    clrErr   = 1'b0;
    loadBusy = 1'b0;
    unique case (state)
      ST_IDLE: if (wrEn) begin
        if (cmdByte == CMD_SETUP && !anyErr) begin
          ctl.startSeq = 1'b1;
          nxtState     = ST_COUNT;
        end else if (cmdByte == CMD_CLEAR) begin
          clrErr = 1'b1;
        end
      end
      ST_COUNT: if (wrEn) begin
        if (countOk) begin
          ctl.takeCount = 1'b1;
          nxtState      = ST_DATA;
        end else begin
          seqErr   = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_DATA: if (wrEn) begin
        if (inRange) begin
          ctl.takeData = 1'b1;
          if (lastData) nxtState = ST_CONFIRM;
        end else begin
          seqErr   = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_CONFIRM: if (wrEn) begin
        if (cmdByte == CMD_CONFIRM) begin
          loadBusy = 1'b1;
          nxtState = ST_PROG;
        end else begin
          seqErr   = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_PROG: if (busyCnt == '0) begin
        ctl.commit = 1'b1;
        nxtState   = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      busyCnt  <= '0;
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
    end else begin
      state <= nxtState;
      if (loadBusy) busyCnt <= CNT_W'(PROG_CYCLES - 1);
      else if (state == ST_PROG) busyCnt <= busyCnt - 1'b1;
      if (seqErr) begin
        progErr  <= 1'b1;
        eraseErr <= 1'b1;
      end else if (clrErr) begin
        progErr  <= 1'b0;
        eraseErr <= 1'b0;
      end
    end
  end

  assign ready = state != ST_PROG;
  assign avail = ready && !anyErr;
endmodule

// File: rtl/bufprog_top.sv
module bufprog_top
  import bufprog_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BUF_BYTES   = 32,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut,
  output logic [7:0]        xStatusOut
);
  dpCtrl_t ctl;
  logic    countOk, inRange, lastData;
  logic    ready, avail, progErr, eraseErr;

  bufprog_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .cmdByte(wrData[7:0]),
    .countOk(countOk), .inRange(inRange), .lastData(lastData),
    .ctl(ctl), .ready(ready), .avail(avail),
    .progErr(progErr), .eraseErr(eraseErr)
  );

  bufprog_dp #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .byteMode(byteMode), .rdAddr(rdAddr), .rdData(rdData),
    .countOk(countOk), .inRange(inRange), .lastData(lastData)
  );

  assign statusOut  = {ready, 1'b0, eraseErr, progErr, 4'b0000};
  assign xStatusOut = {avail, 7'b0000000};
endmodule

// File: rtl/bufprog_chk.sv
module bufprog_chk #(
  parameter int PROG_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [15:0] wrData,
  input logic [7:0] statusOut,
  input logic [7:0] xStatusOut
);
  int busyLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyLen <= 0;
    else if (statusOut[7]) busyLen <= 0;
    else busyLen <= busyLen + 1;
  end

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusOut[7]) |-> busyLen == PROG_CYCLES);

  // R9
  avail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !statusOut[7] |-> !xStatusOut[7]);

  // R4
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusOut[7]) |-> $past(wrEn && wrData[7:0] == 8'hD0));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusOut[4]) |-> $past(wrEn && wrData[7:0] == 8'h50));

  // R3
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusOut[4] == statusOut[5]);

  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut[7] && statusOut[4] && wrEn && wrData[7:0] == 8'hE8) |=> (statusOut[7] && !xStatusOut[7]));
endmodule

bind bufprog_top bufprog_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
  .statusOut(statusOut), .xStatusOut(xStatusOut)
);

// File: tb/tb_bufprog_top.sv
module tb_bufprog_top;
  localparam int PROG_CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic       byteMode = 1'b1;
  logic [6:0] rdAddr = '0;
  logic [7:0] rdData, statusOut, xStatusOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  bufprog_top #(.ADDR_W(7), .BUF_BYTES(32), .PROG_CYCLES(PROG_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .byteMode(byteMode), .rdAddr(rdAddr), .rdData(rdData),
    .statusOut(statusOut), .xStatusOut(xStatusOut)
  );

  function automatic logic [7:0] expStatus(bit rdy, bit err);
    return {rdy, 1'b0, err, err, 4'b0000};
  endfunction

  function automatic logic [7:0] expX(bit av);
    return {av, 7'b0000000};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkStat(input string req, input bit rdy, input bit err, input bit av);
    check(statusOut == expStatus(rdy, err), req, statusOut, expStatus(rdy, err));
    check(xStatusOut == expX(av), req, xStatusOut, expX(av));
  endtask

  task automatic checkArray(input string req);
    int bad = 0;
    int firstAct = 0, firstExp = 0;
    for (int a = 0; a < 128; a++) begin
      rdAddr = 7'(a);
      #1;
      if (rdData !== model[a]) begin
        if (bad == 0) begin firstAct = rdData; firstExp = model[a]; end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [15:0] d, input bit bm);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; byteMode = bm;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitBusy(input string req);
    int lowCnt = 1;
    check(statusOut[7] == 1'b0 && xStatusOut[7] == 1'b0, req, {statusOut, xStatusOut}, 0);
    while (!statusOut[7] && lowCnt < 1000) begin
      @(negedge clk);
      if (!statusOut[7]) lowCnt++;
    end
    check(lowCnt == PROG_CYC, req, lowCnt, PROG_CYC);
  endtask

  // full legal sequence; fixedData < 0 means random data
  task automatic runGood(input bit bm, input logic [6:0] base, input int n,
                         input bit seqAddr, input int fixedData);
    logic [7:0] bb [32];
    bit bmk [32];
    for (int i = 0; i < 32; i++) begin bb[i] = 8'h00; bmk[i] = 1'b0; end
    busWrite(7'(base + 3), 16'h00E8, bm);
    check(xStatusOut == expX(1'b1), "R2 setup", xStatusOut, 8'h80);
    busWrite(7'd0, 16'(n), bm);
    for (int i = 0; i <= n; i++) begin
      int off = (seqAddr || i == 0) ? i : int'($urandom % (n + 1));
      logic [15:0] d = (fixedData < 0) ? 16'($urandom) : 16'(fixedData);
      int idx = bm ? off : 2 * off;
      busWrite(7'(base + off), d, bm);
      bb[idx] = d[7:0]; bmk[idx] = 1'b1;
      if (!bm) begin bb[idx + 1] = d[15:8]; bmk[idx + 1] = 1'b1; end
    end
    busWrite(7'd0, 16'hA5D0, bm);
    waitBusy("R9 busy window");
    for (int i = 0; i < 32; i++) begin
      int bbase = bm ? int'(base) : 2 * int'(base);
      if (bmk[i]) model[(bbase + i) % 128] = model[(bbase + i) % 128] & bb[i];
    end
    checkStat("R9 after busy", 1'b1, 1'b0, 1'b1);
    checkArray("R10 merged array");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int a = 0; a < 128; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkStat("R1 reset", 1'b1, 1'b0, 1'b1);
    checkArray("R1 erased array");

    // R2 stray writes in idle have no effect
    busWrite(7'd5, 16'h0040, 1'b1);
    busWrite(7'd5, 16'h0000, 1'b1);
    busWrite(7'd5, 16'h00D0, 1'b1);
    checkStat("R2 idle ignore", 1'b1, 1'b0, 1'b1);
    checkArray("R2 idle array");

    // R4 R10 byte and word mode directed
    runGood(1'b1, 7'd10, 3, 1'b1, -1);
    runGood(1'b0, 7'd20, 1, 1'b1, -1);
    // R10 bits only clear
    runGood(1'b1, 7'd100, 0, 1'b1, 16'h00F0);
    runGood(1'b1, 7'd100, 0, 1'b1, 16'h000F);
    rdAddr = 7'd100; #1;
    check(rdData == 8'h00, "R10 and-merge", rdData, 8'h00);
    // R3 boundary counts accepted
    runGood(1'b1, 7'd64, 31, 1'b1, -1);
    runGood(1'b0, 7'd0, 15, 1'b1, -1);

    // R3 count too large, byte mode
    busWrite(7'd0, 16'h00E8, 1'b1);
    busWrite(7'd0, 16'h0020, 1'b1);
    checkStat("R3 byte count 20h", 1'b1, 1'b1, 1'b0);
    busWrite(7'd0, 16'h0050, 1'b1);
    checkStat("R8 clear", 1'b1, 1'b0, 1'b1);
    // R3 word mode count 10h
    busWrite(7'd0, 16'h00E8, 1'b0);
    busWrite(7'd0, 16'h0010, 1'b0);
    checkStat("R3 word count 10h", 1'b1, 1'b1, 1'b0);
    busWrite(7'd0, 16'h0050, 1'b0);
    checkStat("R8 clear word", 1'b1, 1'b0, 1'b1);

    // R5 wrong confirm
    busWrite(7'd50, 16'h00E8, 1'b1);
    busWrite(7'd0, 16'h0000, 1'b1);
    busWrite(7'd50, 16'h0000, 1'b1);
    busWrite(7'd50, 16'h00FF, 1'b1);
    checkStat("R5 bad confirm", 1'b1, 1'b1, 1'b0);
    checkArray("R5 no program");
    busWrite(7'd0, 16'h0050, 1'b1);

    // R6 address outside window
    busWrite(7'd60, 16'h00E8, 1'b1);
    busWrite(7'd0, 16'h0001, 1'b1);
    busWrite(7'd60, 16'h0000, 1'b1);
    busWrite(7'd62, 16'h0000, 1'b1);
    checkStat("R6 out of window", 1'b1, 1'b1, 1'b0);
    busWrite(7'd0, 16'h00D0, 1'b1);
    repeat (PROG_CYC + 4) @(negedge clk);
    checkArray("R6 no program");

    // R7 refusal while errors set
    busWrite(7'd70, 16'h00E8, 1'b1);
    checkStat("R7 refused setup", 1'b1, 1'b1, 1'b0);
    busWrite(7'd0, 16'h0000, 1'b1);
    busWrite(7'd70, 16'h0000, 1'b1);
    busWrite(7'd70, 16'h00D0, 1'b1);
    repeat (PROG_CYC + 4) @(negedge clk);
    checkStat("R7 still idle", 1'b1, 1'b1, 1'b0);
    checkArray("R7 no program");
    busWrite(7'd0, 16'h0050, 1'b1);
    checkStat("R8 clear again", 1'b1, 1'b0, 1'b1);

    // R11 writes during busy ignored
    busWrite(7'd30, 16'h00E8, 1'b1);
    busWrite(7'd0, 16'h0000, 1'b1);
    busWrite(7'd30, 16'h0000, 1'b1);
    busWrite(7'd30, 16'h00D0, 1'b1);
    model[30] = 8'h00;
    busWrite(7'd40, 16'h00E8, 1'b1);
    busWrite(7'd0, 16'h0050, 1'b1);
    while (!statusOut[7]) @(negedge clk);
    busWrite(7'd0, 16'h0000, 1'b1);
    busWrite(7'd40, 16'h0000, 1'b1);
    busWrite(7'd40, 16'h00D0, 1'b1);
    repeat (PROG_CYC + 4) @(negedge clk);
    checkStat("R11 no hidden sequence", 1'b1, 1'b0, 1'b1);
    checkArray("R11 array");

    // random legal sequences
    for (int k = 0; k < 25; k++) begin
      bit bm = 1'($urandom);
      int n = bm ? int'($urandom % 32) : int'($urandom % 16);
      runGood(bm, 7'($urandom), n, 1'($urandom), -1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule